// File: doc/BRIEF.md
# Sparse Ling Prefix Adder

A combinational two-operand adder that returns the low 32 bits of the sum of its inputs. Carries do not travel through the tree. The tree carries Ling pseudo-carries instead. A pseudo-carry at a position is its own generate ORed with the true carry arriving from below. The true carry can always be recovered by ANDing the pseudo-carry with that position's transmit bit (a OR b). Each node of the tree holds a pair: a span pseudo-carry and a span transmit product. The transmit product is taken one bit lower than the span itself, which is the shift that Ling's recurrence needs.

The tree is sparse. The leaves are 2-bit groups, and group pseudo-carries exist only at every odd bit. The first level builds the 2-bit pair for each group. Four further Kogge-Stone style levels then combine groups 1, 2, 4 and 8 apart, so the full 32-bit width takes five recurrence levels in total. Each group precomputes two candidate 2-bit sums, one for an incoming pseudo-carry of 0 and one for 1. The pseudo-carry of all bits below the group then selects between them through a 2-to-1 multiplexer. The transmit bit under the group is folded into the "1" candidate, so the tree never needs to form a true carry.

The adder has no carry-in and no carry-out. The width is a parameter, set to 32 by default.

Top module: `sparse_ling_adder`

## Requirements
- R1: `sum` equals `(opA + opB) mod 2^32` for any pair of operands, and it changes in the same cycle as its inputs, holding no state.
- R2: A carry out of bit 31 is dropped. For example, 0xFFFFFFFF + 0x00000001 gives 0x00000000, and 0x80000000 + 0x80000000 gives 0x00000000.
- R3: A zero operand leaves the other operand unchanged at `sum`, and 0 + 0 gives 0.
- R4: A carry generated at bit 0 ripples through an unbroken run of transmitting bits of any length. For example, 0x7FFFFFFF + 1 gives 0x80000000, and 0x0000FFFF + 1 gives 0x00010000.
- R5: Alternating bit patterns add correctly. 0xAAAAAAAA + 0x55555555 gives 0xFFFFFFFF, with every bit transmitting and none generating. 0xAAAAAAAA + 0xAAAAAAAA gives 0x55555554, and 0x55555555 + 0x55555555 gives 0xAAAAAAAA.
- R6: A carry entering any bit position k is delivered correctly, whether it arrives inside a 2-bit group (k odd) or across a group boundary through the multiplexer (k even). (2^k − 1) + 1 gives 2^k, and 2^(k−1) + 2^(k−1) gives 2^k.
- R7: For every group m, the prefix pseudo-carry over bits 2m+1..0 equals g(2m+1) OR (the true carry into bit 2m+1). ANDing it with t(2m+1) gives the true carry out of bit 2m+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First addend |
| opB | input | 32 | Second addend |
| sum | output | 32 | Low 32 bits of opA + opB |

## Verification
The bench targets carries that must cross many groups. Examples are all-ones plus one and 0x7FFFFFFF plus one. A mistake in a late prefix level, or in the shifted transmit product, shows up here as a wrong bit high in the word while the low bits stay correct. A walk of single carries into every bit position separates the two delivery paths. If the in-group carry is recovered wrongly, only odd bits break. If the multiplexer select or the folded transmit bit is wrong, only even bits break. Alternating patterns make all bits transmit with no generate, which catches a candidate sum that treats a transmit bit as a generate. Random vectors are compared against a behavioural addition.

// File: rtl/ling_pkg.sv
package ling_pkg;
  // One prefix node: span pseudo-carry and the transmit product shifted one bit down
  typedef struct packed {
    logic pch;
    logic tsh;
  } lingSpan_t;
endpackage

// File: rtl/ling_bit_cells.sv
module ling_bit_cells
  import ling_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int GROUPS = WIDTH / 2
) (
  input  logic [WIDTH-1:0]            opA,
  input  logic [WIDTH-1:0]            opB,
  output logic [WIDTH-1:0]            gen,
  output logic [WIDTH-1:0]            trn,
  output logic [WIDTH-1:0]            dif,
  output lingSpan_t [GROUPS-1:0]      leaf
);
  assign gen = opA & opB;
  assign trn = opA | opB;
  assign dif = opA ^ opB;

  // First level: 2-bit group pairs. h over [2m+1:2m] reduces to g(2m+1) | g(2m).
  for (genvar m = 0; m < GROUPS; m++) begin : gGrp
    assign leaf[m].pch = gen[2*m+1] | gen[2*m];
    if (m == 0) begin : gBottom
      assign leaf[m].tsh = 1'b0;  // t(-1) is zero: no carry-in
    end else begin : gUpper
      assign leaf[m].tsh = trn[2*m] & trn[2*m-1];
    end
  end
endmodule

// File: rtl/ling_prefix_tree.sv
module ling_prefix_tree
  import ling_pkg::*;
#(
  parameter int GROUPS = 16,
  localparam int LEVELS = $clog2(GROUPS)
) (
  input  lingSpan_t [GROUPS-1:0] leaf,
  output logic [GROUPS-1:0]      grpPch
);
  logic [LEVELS:0][GROUPS-1:0] pchLvl;
  logic [LEVELS:0][GROUPS-1:0] tshLvl;

  for (genvar m = 0; m < GROUPS; m++) begin : gLeaf
    assign pchLvl[0][m] = leaf[m].pch;
    assign tshLvl[0][m] = leaf[m].tsh;
  end

  // Dense combine over groups: distance doubles every level
  for (genvar s = 0; s < LEVELS; s++) begin : gLvl
    localparam int DIST = 1 << s;
    for (genvar m = 0; m < GROUPS; m++) begin : gNode
      if (m >= DIST) begin : gCombine
        assign pchLvl[s+1][m] = pchLvl[s][m] | (tshLvl[s][m] & pchLvl[s][m-DIST]);
        assign tshLvl[s+1][m] = tshLvl[s][m] & tshLvl[s][m-DIST];
      end else begin : gPass
        assign pchLvl[s+1][m] = pchLvl[s][m];
        assign tshLvl[s+1][m] = tshLvl[s][m];
      end
    end
  end

  assign grpPch = pchLvl[LEVELS];
endmodule

// File: rtl/ling_sum_select.sv
module ling_sum_select #(
  parameter int WIDTH = 32,
  localparam int GROUPS = WIDTH / 2
) (
  input  logic [WIDTH-1:0]  gen,
  input  logic [WIDTH-1:0]  trn,
  input  logic [WIDTH-1:0]  dif,
  input  logic [GROUPS-1:0] grpPch,
  output logic [WIDTH-1:0]  sum
);
  for (genvar m = 0; m < GROUPS; m++) begin : gGrp
    logic tPrev;
    logic sel;
    logic [1:0] cand0;
    logic [1:0] cand1;
    if (m == 0) begin : gBottom
      assign tPrev = 1'b0;
      assign sel   = 1'b0;
    end else begin : gUpper
      assign tPrev = trn[2*m-1];
      assign sel   = grpPch[m-1];
    end
    // Incoming true carry is tPrev when the pseudo-carry is 1, else 0
    assign cand0 = {dif[2*m+1] ^ gen[2*m], dif[2*m]};
    assign cand1 = {dif[2*m+1] ^ (gen[2*m] | (trn[2*m] & tPrev)), dif[2*m] ^ tPrev};
    assign sum[2*m+1:2*m] = sel ? cand1 : cand0;
  end
endmodule

// File: rtl/sparse_ling_adder.sv
module sparse_ling_adder
  import ling_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sum
);
  localparam int GROUPS = WIDTH / 2;

  logic [WIDTH-1:0]       gen;
  logic [WIDTH-1:0]       trn;
  logic [WIDTH-1:0]       dif;
  lingSpan_t [GROUPS-1:0] leaf;
  logic [GROUPS-1:0]      grpPch;

  ling_bit_cells #(.WIDTH(WIDTH)) uCells (
    .opA(opA), .opB(opB), .gen(gen), .trn(trn), .dif(dif), .leaf(leaf)
  );

  ling_prefix_tree #(.GROUPS(GROUPS)) uTree (
    .leaf(leaf), .grpPch(grpPch)
  );

  ling_sum_select #(.WIDTH(WIDTH)) uSel (
    .gen(gen), .trn(trn), .dif(dif), .grpPch(grpPch), .sum(sum)
  );

  // Behavioural carry out of bit k, used only by the checks below
  function automatic logic refCarryOut(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                                       input int k);
    logic [WIDTH:0] msk;
    logic [WIDTH:0] tot;
    msk = ({{WIDTH{1'b0}}, 1'b1} << (k + 1)) - 1'b1;
    tot = ({1'b0, a} & msk) + ({1'b0, b} & msk);
    return tot[k+1];
  endfunction

  // R1: full result against a behavioural addition
  always_comb begin
    if (!$isunknown({opA, opB}))
      a_r1_sum_matches_reference: assert (sum == WIDTH'(opA + opB))
        else $error("R1 sum mismatch");
  end

  for (genvar m = 0; m < GROUPS; m++) begin : gChk
    always_comb begin
      if (!$isunknown({opA, opB})) begin
        // R7: tree output recovers the true carry out of the group's top bit
        a_r7_group_carry: assert ((grpPch[m] & opA[2*m+1] | grpPch[m] & opB[2*m+1])
                                  == refCarryOut(opA, opB, 2*m+1))
          else $error("R7 group carry mismatch");
        // R7: Ling identity, pseudo-carry = generate or incoming true carry
        a_r7_ling_identity: assert (grpPch[m] ==
            ((opA[2*m+1] & opB[2*m+1]) | refCarryOut(opA, opB, 2*m)))
          else $error("R7 pseudo-carry identity mismatch");
        // R6: a clear pseudo-carry means no carry crosses into the next group
        a_r6_no_false_carry: assert (grpPch[m] || !refCarryOut(opA, opB, 2*m+1))
          else $error("R6 carry without pseudo-carry");
      end
    end
  end
endmodule

// File: tb/sim_sparse_ling_adder.sv
module sim_sparse_ling_adder;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [W-1:0] sum;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [W-1:0] expQ[$];
  string reqQ[$];

  always #2.5 clk = ~clk;  // 200 MHz

  sparse_ling_adder #(.WIDTH(W)) u0 (.opA(opA), .opB(opB), .sum(sum));

  // Reference model: plain integer addition truncated to W bits
  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
    longint unsigned t;
    t = longint'(a) + longint'(b);
    return W'(t);
  endfunction

  // Apply one vector just after a rising edge, then check it at the falling edge
  task automatic runVec(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    logic [W-1:0] expv;
    logic [W-1:0] got;
    string rq;
    @(posedge clk);
    #1;
    opA = a;
    opB = b;
    expQ.push_back(model(a, b));
    reqQ.push_back(req);
    @(negedge clk);
    expv = expQ.pop_front();
    rq = reqQ.pop_front();
    got = sum;
    testsRun++;
    if (got !== expv) begin
      testsFailed++;
      $display("FAIL %s: a=%08h b=%08h sum=%08h expected=%08h", rq, a, b, got, expv);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R3: idle value with zero operands
    @(negedge clk);
    testsRun++;
    if (sum !== '0) begin
      testsFailed++;
      $display("FAIL R3: reset-time sum=%08h expected=00000000", sum);
    end
    // R3: zero operand identity
    runVec(32'h0000_0000, 32'h0000_0000, "R3");
    runVec(32'hDEAD_BEEF, 32'h0000_0000, "R3");
    runVec(32'h0000_0000, 32'h1234_5678, "R3");
    // R2: overflow discarded
    runVec(32'hFFFF_FFFF, 32'h0000_0001, "R2");
    runVec(32'h8000_0000, 32'h8000_0000, "R2");
    runVec(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
    // R4: long transmit chains
    runVec(32'h7FFF_FFFF, 32'h0000_0001, "R4");
    runVec(32'h0000_FFFF, 32'h0000_0001, "R4");
    runVec(32'h0000_0001, 32'h7FFF_FFFF, "R4");
    // R5: alternating patterns
    runVec(32'hAAAA_AAAA, 32'h5555_5555, "R5");
    runVec(32'hAAAA_AAAA, 32'hAAAA_AAAA, "R5");
    runVec(32'h5555_5555, 32'h5555_5555, "R5");
    runVec(32'h5555_5555, 32'hAAAA_AAAB, "R5");
    // R6 and R7: a carry landing at every bit position, both delivery paths
    for (int k = 1; k < W; k++) begin
      runVec((32'h1 << k) - 32'h1, 32'h1, "R6");
      runVec(32'h1 << (k - 1), 32'h1 << (k - 1), "R7");
    end
    // R1: random operands, same-cycle result
    for (int i = 0; i < 2000; i++) begin
      runVec($urandom, $urandom, "R1");
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL R1: watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule